// File: doc/BRIEF.md
# Register ALU with Result Tracking

This block is the arithmetic and status unit of a small 16-register pseudo-CPU. It takes the accumulator (R0) and one selected register Rn, and for the three arithmetic instruction groups it forms a 16-bit sum or difference. Add and subtract return their result to R0. Compare returns its difference to the fixed register R13, where a later branch can test it. Memory access and instruction fetch are handled elsewhere. The block only sees the instruction group, the register index and the two operand values, which come with a valid strobe.

The block does not keep a set of condition flags. Its status register (the high byte of R14) holds a pointer to the register that received the most recent result, together with one carry bit. Every register-group instruction moves that pointer. The arithmetic groups set the carry, and all other register groups clear it. A later branch unit uses the pointer to find which register to test for zero, sign or minus one.

The result and the updated status appear together, one clock after the strobe. The surrounding register file writes the result into the register named on `res_dest`.

Top module: `regalu_track`

## Requirements
- R1: While `rst` is high, and on the first cycle after it, `status_byte` is 0x00 and `res_valid` is low.
- R2: Group code 0xC with `op_valid` high gives `res_value` = (`acc_val` + `reg_val`) mod 2^16 with carry-in 0, `res_dest` = 0 and `res_valid` high. The carry bit is the carry out of bit 15.
- R3: Group code 0xD gives `res_value` = (`acc_val` − `reg_val`) mod 2^16 with `res_dest` = 0. The carry bit is 1 exactly when `acc_val` >= `reg_val` (no borrow).
- R4: Group code 0xB gives the same difference and carry as R3, but with `res_dest` = 13.
- R5: `status_byte` holds the marked register index in bits 4:1 and the carry in bit 0. Bits 7:5 are zero. After an add or subtract it reads 0x00 or 0x01, and after a compare it reads 0x1A or 0x1B.
- R6: Group codes 0x1, 0x2, 0x3, 0xE and 0xF set `status_byte` to Rn×2, which marks Rn and clears the carry. They leave `res_valid` low.
- R7: Group codes 0x4 through 0xA set `status_byte` to 0x00, which marks R0 and clears the carry. They leave `res_valid` low.
- R8: Group code 0x0, or `op_valid` low, leaves `status_byte` unchanged and `res_valid` low.
- R9: Result and status come from the inputs sampled on the same rising edge. Both are visible in the cycle right after that edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Instruction strobe |
| op_group | input | 4 | Instruction group (upper opcode nibble) |
| op_reg | input | 4 | Register index Rn (lower opcode nibble) |
| acc_val | input | 16 | Current value of R0 |
| reg_val | input | 16 | Current value of Rn |
| res_valid | output | 1 | Result must be written back this cycle |
| res_value | output | 16 | Sum or difference |
| res_dest | output | 4 | Register index to write |
| status_byte | output | 8 | Prior-result index ×2 with carry in bit 0 |

## Verification
The bench builds the block with its default parameters: 16-bit data, 4-bit indices, an 8-bit status byte and an 8-bit carry slice. These values put three cases in reach: the carry crossing from the low slice into the high slice (0x00FF + 1), wrap-around at the full width, and marking of the highest register index (R15 gives 0x1E). A scoreboard predicts the status byte across a mixed sequence of groups. This also checks that idle cycles and group 0 keep the previous pointer and carry.

// File: rtl/regalu_pkg.sv
package regalu_pkg;

    localparam int GRP_W = 4;

    typedef enum logic [GRP_W-1:0] {
        GRP_CTRL  = 4'h0,
        GRP_SET   = 4'h1,
        GRP_LD    = 4'h2,
        GRP_ST    = 4'h3,
        GRP_LDI   = 4'h4,
        GRP_STI   = 4'h5,
        GRP_LDID  = 4'h6,
        GRP_STID  = 4'h7,
        GRP_POP   = 4'h8,
        GRP_PUSH  = 4'h9,
        GRP_POPD  = 4'hA,
        GRP_CMP   = 4'hB,
        GRP_ADD   = 4'hC,
        GRP_SUB   = 4'hD,
        GRP_INC   = 4'hE,
        GRP_DEC   = 4'hF
    } grp_e;

    typedef enum logic [1:0] {
        MARK_NONE = 2'd0,
        MARK_RN   = 2'd1,
        MARK_ACC  = 2'd2,
        MARK_CMP  = 2'd3
    } mark_e;

    typedef struct packed {
        logic  arith;
        logic  subtract;
        mark_e mark;
    } alu_ctl_t;

    function automatic logic grp_is_memory(input logic [GRP_W-1:0] g);
        return (g >= GRP_LDI) && (g <= GRP_POPD);
    endfunction

    function automatic logic grp_is_arith(input logic [GRP_W-1:0] g);
        return (g == GRP_CMP) || (g == GRP_ADD) || (g == GRP_SUB);
    endfunction

endpackage

// File: rtl/regalu_decode.sv
module regalu_decode
    import regalu_pkg::*;
(
    input  logic             valid,
    input  logic [GRP_W-1:0] group,
    output alu_ctl_t         ctl
);
    always_comb begin
        ctl = '{arith: 1'b0, subtract: 1'b0, mark: MARK_NONE};
        if (valid) begin
            if (group == GRP_CTRL) begin
                ctl.mark = MARK_NONE;
            end else if (grp_is_arith(group)) begin
                ctl.arith    = 1'b1;
                ctl.subtract = (group != GRP_ADD);
                ctl.mark     = (group == GRP_CMP) ? MARK_CMP : MARK_ACC;
            end else if (grp_is_memory(group)) begin
                ctl.mark = MARK_ACC;
            end else begin
                ctl.mark = MARK_RN;
            end
        end
    end
endmodule

// File: rtl/regalu_addsub.sv
module regalu_addsub #(
    parameter int DATA_W  = 16,
    parameter int SLICE_W = 8
) (
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    input  logic              sub,
    output logic [DATA_W-1:0] sum,
    output logic              carry_out
);
    localparam int N_SLICES = DATA_W / SLICE_W;

    logic [DATA_W-1:0] b_eff;
    logic [N_SLICES:0] cy;

    assign b_eff = sub ? ~b : b;
    assign cy[0] = sub;

    for (genvar s = 0; s < N_SLICES; s++) begin : g_slice
        logic [SLICE_W:0] part;
        assign part = {1'b0, a[s*SLICE_W +: SLICE_W]}
                    + {1'b0, b_eff[s*SLICE_W +: SLICE_W]}
                    + {{SLICE_W{1'b0}}, cy[s]};
        assign sum[s*SLICE_W +: SLICE_W] = part[SLICE_W-1:0];
        assign cy[s+1] = part[SLICE_W];
    end

    assign carry_out = cy[N_SLICES];
endmodule

// File: rtl/regalu_status.sv
module regalu_status #(
    parameter int IDX_W  = 4,
    parameter int STAT_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              upd,
    input  logic [IDX_W-1:0]  mark_idx,
    input  logic              carry,
    output logic [STAT_W-1:0] status
);
    localparam int PAD_W = STAT_W - IDX_W - 1;

    logic [STAT_W-1:0] next_status;

    if (PAD_W > 0) begin : g_pad
        assign next_status = {{PAD_W{1'b0}}, mark_idx, carry};
    end else begin : g_nopad
        assign next_status = {mark_idx, carry};
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            status <= '0;
        end else if (upd) begin
            status <= next_status;
        end
    end
endmodule

// File: rtl/regalu_track.sv
module regalu_track
    import regalu_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int IDX_W   = 4,
    parameter int SLICE_W = 8,
    parameter int STAT_W  = 8,
    parameter int CMP_IDX = 13
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [3:0]        op_group,
    input  logic [IDX_W-1:0]  op_reg,
    input  logic [DATA_W-1:0] acc_val,
    input  logic [DATA_W-1:0] reg_val,
    output logic              res_valid,
    output logic [DATA_W-1:0] res_value,
    output logic [IDX_W-1:0]  res_dest,
    output logic [STAT_W-1:0] status_byte
);
    localparam logic [IDX_W-1:0] ACC_I = '0;
    localparam logic [IDX_W-1:0] CMP_I = IDX_W'(CMP_IDX);

    alu_ctl_t          ctl;
    logic [DATA_W-1:0] sum;
    logic              cout;
    logic [IDX_W-1:0]  mark_idx;
    logic              st_carry;
    logic              st_upd;

    regalu_decode u_dec (
        .valid (op_valid),
        .group (op_group),
        .ctl   (ctl)
    );

    regalu_addsub #(.DATA_W(DATA_W), .SLICE_W(SLICE_W)) u_add (
        .a         (acc_val),
        .b         (reg_val),
        .sub       (ctl.subtract),
        .sum       (sum),
        .carry_out (cout)
    );

    always_comb begin
        unique case (ctl.mark)
            MARK_RN:  mark_idx = op_reg;
            MARK_CMP: mark_idx = CMP_I;
            default:  mark_idx = ACC_I;
        endcase
    end

    assign st_carry = ctl.arith & cout;
    assign st_upd   = (ctl.mark != MARK_NONE);

    regalu_status #(.IDX_W(IDX_W), .STAT_W(STAT_W)) u_stat (
        .clk      (clk),
        .rst      (rst),
        .upd      (st_upd),
        .mark_idx (mark_idx),
        .carry    (st_carry),
        .status   (status_byte)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            res_valid <= 1'b0;
            res_value <= '0;
            res_dest  <= '0;
        end else begin
            res_valid <= ctl.arith;
            if (ctl.arith) begin
                res_value <= sum;
                res_dest  <= mark_idx;
            end
        end
    end
endmodule

// File: rtl/regalu_track_chk.sv
module regalu_track_chk
    import regalu_pkg::*;
#(
    parameter int DATA_W  = 16,
    parameter int IDX_W   = 4,
    parameter int STAT_W  = 8,
    parameter int CMP_IDX = 13
) (
    input logic              clk,
    input logic              rst,
    input logic              op_valid,
    input logic [3:0]        op_group,
    input logic [IDX_W-1:0]  op_reg,
    input logic [DATA_W-1:0] acc_val,
    input logic [DATA_W-1:0] reg_val,
    input logic              res_valid,
    input logic [IDX_W-1:0]  res_dest,
    input logic [STAT_W-1:0] status_byte
);
    logic is_rn_grp;
    assign is_rn_grp = (op_group == GRP_SET) || (op_group == GRP_LD) || (op_group == GRP_ST)
                    || (op_group == GRP_INC) || (op_group == GRP_DEC);

    // R2
    a_r2_add_dest: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_group == GRP_ADD) |=> (res_valid && res_dest == '0 && status_byte[IDX_W:1] == '0));

    // R3
    a_r3_sub_carry: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_group == GRP_SUB) |=> (status_byte[0] == ($past(acc_val) >= $past(reg_val))));

    // R4
    a_r4_cmp_dest: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_group == GRP_CMP) |=> (res_valid && res_dest == IDX_W'(CMP_IDX)
                                               && status_byte[IDX_W:1] == IDX_W'(CMP_IDX)));

    // R5
    a_r5_pad_zero: assert property (@(posedge clk) disable iff (rst)
        status_byte[STAT_W-1:IDX_W+1] == '0);

    // R6
    a_r6_mark_rn: assert property (@(posedge clk) disable iff (rst)
        (op_valid && is_rn_grp) |=> (status_byte[IDX_W:1] == $past(op_reg) && !status_byte[0] && !res_valid));

    // R7
    a_r7_mark_acc: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_group >= GRP_LDI && op_group <= GRP_POPD) |=> (status_byte == '0 && !res_valid));

    // R8
    a_r8_idle: assert property (@(posedge clk) disable iff (rst)
        (!op_valid || op_group == GRP_CTRL) |=> ($stable(status_byte) && !res_valid));
endmodule

bind regalu_track regalu_track_chk #(
    .DATA_W(DATA_W), .IDX_W(IDX_W), .STAT_W(STAT_W), .CMP_IDX(CMP_IDX)
) u_chk (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_group(op_group), .op_reg(op_reg),
    .acc_val(acc_val), .reg_val(reg_val), .res_valid(res_valid), .res_dest(res_dest),
    .status_byte(status_byte)
);

// File: tb/regalu_track_bench.sv
`timescale 1ns/1ps
module regalu_track_bench;
    logic        clk = 1'b0;
    logic        rst;
    logic        op_valid;
    logic [3:0]  op_group;
    logic [3:0]  op_reg;
    logic [15:0] acc_val;
    logic [15:0] reg_val;
    logic        res_valid;
    logic [15:0] res_value;
    logic [3:0]  res_dest;
    logic [7:0]  status_byte;

    int total = 0;
    int bad   = 0;
    int cyc   = 0;
    logic [7:0] exp_st = 8'h00;

    typedef struct {
        int          due;
        logic        vld;
        logic [15:0] val;
        logic [3:0]  dst;
        logic [7:0]  st;
        string       tag;
    } item_t;
    item_t q[$];

    always #5 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    regalu_track u_regalu_track (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_group(op_group), .op_reg(op_reg),
        .acc_val(acc_val), .reg_val(reg_val), .res_valid(res_valid), .res_value(res_value),
        .res_dest(res_dest), .status_byte(status_byte)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic en, input logic [3:0] g, input logic [3:0] rn,
                         input logic [15:0] a, input logic [15:0] b, input string tag);
        item_t it;
        logic [16:0] wide;
        @(posedge clk);
        #2;
        op_valid = en; op_group = g; op_reg = rn; acc_val = a; reg_val = b;
        it.due = cyc + 1; it.tag = tag; it.vld = 1'b0; it.val = 16'h0; it.dst = 4'h0;
        if (en && g != 4'h0) begin
            if (g == 4'hC) begin
                wide = {1'b0, a} + {1'b0, b};
                it.vld = 1'b1; it.val = wide[15:0]; it.dst = 4'd0;
                exp_st = {7'b0, wide[16]};
            end else if (g == 4'hD || g == 4'hB) begin
                it.vld = 1'b1; it.val = a - b;
                it.dst = (g == 4'hB) ? 4'd13 : 4'd0;
                exp_st = {3'b0, it.dst, (a >= b)};
            end else if (g >= 4'h4 && g <= 4'hA) begin
                exp_st = 8'h00;
            end else begin
                exp_st = {3'b0, rn, 1'b0};
            end
        end
        it.st = exp_st;
        q.push_back(it);
    endtask

    // monitor: scoreboard pop and compare
    initial begin
        forever begin
            @(posedge clk);
            #4;
            while (q.size() > 0 && q[0].due == cyc) begin
                item_t it;
                it = q.pop_front();
                check({it.tag, " valid"}, 32'(res_valid), 32'(it.vld));
                check({it.tag, " status"}, 32'(status_byte), 32'(it.st));
                if (it.vld) begin
                    check({it.tag, " value"}, 32'(res_value), 32'(it.val));
                    check({it.tag, " dest"}, 32'(res_dest), 32'(it.dst));
                end
            end
        end
    end

    initial begin
        #100000;
        bad++;
        total++;
        $display("FAIL watchdog: actual=hung expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        rst = 1'b1; op_valid = 1'b1; op_group = 4'hC; op_reg = 4'h3;
        acc_val = 16'hFFFF; reg_val = 16'h0001;
        repeat (3) @(posedge clk);
        #4;
        check("R1 reset status", 32'(status_byte), 32'h0);
        check("R1 reset valid", 32'(res_valid), 32'h0);
        #1 rst = 1'b0; op_valid = 1'b0;
        @(posedge clk);
        #4;
        check("R1 post-reset status", 32'(status_byte), 32'h0);
        check("R1 post-reset valid", 32'(res_valid), 32'h0);

        drive(1, 4'hC, 4'd5, 16'h0001, 16'h0002, "R2 add small");
        drive(1, 4'hC, 4'd2, 16'hFFFF, 16'h0001, "R2 add wrap carry");
        drive(1, 4'hC, 4'd1, 16'h00FF, 16'h0001, "R2 add slice carry");
        drive(1, 4'hD, 4'd4, 16'h0005, 16'h0003, "R3 sub no borrow");
        drive(1, 4'hD, 4'd4, 16'h0003, 16'h0005, "R3 sub borrow");
        drive(1, 4'hD, 4'd9, 16'h8000, 16'h8000, "R3 sub equal");
        drive(1, 4'hB, 4'd6, 16'h1234, 16'h1234, "R4 cmp equal");
        drive(1, 4'hB, 4'd6, 16'h0001, 16'h0002, "R4 cmp less");
        drive(1, 4'h1, 4'd7, 16'h0000, 16'h0000, "R6 set marks rn");
        drive(1, 4'hF, 4'd15, 16'hFFFF, 16'hFFFF, "R6 dec marks r15");
        drive(1, 4'h0, 4'd3, 16'h0000, 16'h0000, "R8 group0 keeps");
        drive(0, 4'hC, 4'd3, 16'hFFFF, 16'hFFFF, "R8 idle keeps");
        drive(1, 4'h2, 4'd11, 16'h0000, 16'h0000, "R6 load marks rn");
        drive(1, 4'h5, 4'd9, 16'h0000, 16'h0000, "R7 store-ind marks r0");
        drive(1, 4'hB, 4'd0, 16'hF000, 16'h0001, "R5 cmp status 1B");
        drive(1, 4'hA, 4'd2, 16'h0000, 16'h0000, "R7 popd marks r0");
        drive(1, 4'hE, 4'd3, 16'h0000, 16'h0000, "R6 inc clears carry");
        drive(1, 4'hC, 4'd8, 16'h8000, 16'h8000, "R9 add then idle");
        drive(0, 4'h0, 4'd0, 16'h0000, 16'h0000, "R9 idle after");
        repeat (4) @(posedge clk);
        #6;
        check("R9 queue drained", 32'(q.size()), 32'h0);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule